// File: doc/BRIEF.md
# DDR3 Command and Address Encoder

This block sits between a memory scheduler and the DDR3 command pins. The scheduler hands it one request at a time over a valid/ready handshake. A request carries an opcode, a bank and an address field. Depending on the opcode, the address field holds a row, a column or a mode-register value. Two flags ride along: one selects auto-precharge, precharge-all or long ZQ calibration, and the other selects burst chop. Each accepted request becomes exactly one registered command cycle on CKE, CS#, RAS#, CAS#, WE#, BA and A. When nothing is requested, the encoder drives a NOP.

The encoder keeps its own copies of the first three mode registers. It fills them from mode-load commands and decodes CAS latency, CAS write latency, additive latency, read latency and write latency from them. Downstream data-path logic can then align its bursts to these values.

Power-down entry and self-refresh entry leave the encoder in a low-power state with CKE low. It stays there until the next valid request arrives. That request first causes one wake cycle, with CKE high and the device deselected, and is accepted on the cycle after. The encoder enforces no timing parameters between commands.

Top module: `ddrcmd_encoder`

## Requirements
- R1: While reset is low and after it is released, the encoder drives CKE low, CS#/RAS#/CAS#/WE# high, BA and A zero, and ready low. All mode shadows read zero, so CL=4, CWL=5, AL=0, RL=4 and WL=5.
- R2: An accepted request drives {CS#,RAS#,CAS#,WE#} on the next clock edge, with CKE high. The opcode codes on reqOp and the pin patterns are:
  - mode load: opcode 0, pins 0000
  - refresh: opcode 1, pins 0001
  - precharge: opcode 2, pins 0010
  - activate: opcode 3, pins 0011
  - write: opcode 4, pins 0100
  - read: opcode 5, pins 0101
  - ZQ calibration: opcode 6, pins 0110
  - NOP: opcode 7, pins 0111
  - Opcodes 11 to 15 behave as NOP.
- R3: Deselect (opcode 8) drives CKE high and all four command pins high, with BA and A zero.
- R4: Power-down entry (opcode 9) drives CKE low with all command pins high and drops ready. While no request is valid, CKE stays low and CS# stays high.
- R5: Self-refresh entry (opcode 10) drives CKE low with the refresh pattern 0001 for one cycle. While no request is valid, it then drives CKE low with all command pins high, and ready stays low.
- R6: A valid request seen in the low-power state produces one wake cycle with CKE high and all command pins high, and raises ready. The request is accepted on the following edge.
- R7: Reads and writes drive the bank on BA. Column bits [9:0] go to A[9:0], column bit 10 goes to A[11], and column bits 11 and up go to A[13] and up. The auto-precharge flag goes on A[10] and the burst-chop flag on A[12].
- R8: Precharge drives the bank on BA and the precharge-all flag on A[10], with the other A bits zero. ZQ calibration drives BA zero and the long-calibration flag on A[10], with the other A bits zero.
- R9: A mode load passes bank and address to BA and A. Banks 0, 1 and 2 update the corresponding shadow, and a mode load to any other bank leaves all latency outputs unchanged.
- R10: CL equals {MR0[2],MR0[6:4]}+4, and CWL equals MR2[5:3]+5.
- R11: AL is 0 when MR1[4:3] is 00, and otherwise CL minus MR1[4:3]. RL equals CL+AL and WL equals CWL+AL.
- R12: With ready high and no valid request, the encoder drives a NOP with CKE high and BA and A zero.
- R13: Activate drives the bank on BA and the whole address field on A. Refresh drives BA and A zero regardless of the request fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when valid |
| reqOp | input | 4 | Request opcode |
| reqBank | input | BANK_W | Bank address |
| reqAddr | input | ADDR_W | Row, column or mode value |
| reqAutoPre | input | 1 | Auto-precharge, precharge-all or long ZQ flag |
| reqBurstChop | input | 1 | Burst-chop flag for reads and writes |
| memCke | output | 1 | Clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | BANK_W | Bank pins |
| memAddr | output | ADDR_W | Address pins |
| casLat | output | 6 | CAS latency |
| casWrLat | output | 6 | CAS write latency |
| addLat | output | 6 | Additive latency |
| rdLat | output | 6 | Read latency |
| wrLat | output | 6 | Write latency |

## Verification
The hardest situation to reach is the exit from low power. A request must be presented while ready is low, and the bench must watch the wake cycle and the deferred acceptance separately. The stimulus enters power-down and self-refresh, idles several cycles with the request line low, and then raises a request. It checks the wake cycle and the accepted command on successive clock edges. Additive latency is driven through every MR1 selection after CL has been moved off its reset value, so that the subtraction is exercised with nonzero operands.

// File: rtl/ddrcmd_pkg.sv
package ddrcmd_pkg;

  typedef enum logic [3:0] {
    OP_MODE_LOAD    = 4'd0,
    OP_REFRESH      = 4'd1,
    OP_PRECHARGE    = 4'd2,
    OP_ACTIVATE     = 4'd3,
    OP_WRITE        = 4'd4,
    OP_READ         = 4'd5,
    OP_ZQ_CAL       = 4'd6,
    OP_NOP          = 4'd7,
    OP_DESELECT     = 4'd8,
    OP_POWER_DOWN   = 4'd9,
    OP_SELF_REFRESH = 4'd10
  } reqOp_e;

  localparam int LAT_W = 6;

  // Strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic issue;   // request accepted this edge
    logic wake;    // leaving low power
    logic sleep;   // idling in low power
  } strobe_t;

  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } cmdPins_t;

  localparam cmdPins_t PINS_MODE_LOAD = 4'b0000;
  localparam cmdPins_t PINS_REFRESH   = 4'b0001;
  localparam cmdPins_t PINS_PRECHARGE = 4'b0010;
  localparam cmdPins_t PINS_ACTIVATE  = 4'b0011;
  localparam cmdPins_t PINS_WRITE     = 4'b0100;
  localparam cmdPins_t PINS_READ      = 4'b0101;
  localparam cmdPins_t PINS_ZQ_CAL    = 4'b0110;
  localparam cmdPins_t PINS_NOP       = 4'b0111;
  localparam cmdPins_t PINS_DESELECT  = 4'b1111;

endpackage

// File: rtl/ddrcmd_ctrl.sv
module ddrcmd_ctrl
  import ddrcmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    [3:0] reqOp,
  output logic    reqReady,
  output strobe_t strobe
);

  logic lowPower;
  logic accept;
  logic enterLp;

  assign reqReady = !lowPower;
  assign accept   = reqValid && !lowPower;
  assign enterLp  = accept && ((reqOp == OP_POWER_DOWN) || (reqOp == OP_SELF_REFRESH));

  always_comb begin
    strobe.issue = accept;
    strobe.wake  = reqValid && lowPower;
    strobe.sleep = !reqValid && lowPower;
  end

  // Reset leaves the encoder asleep: CKE stays low until the first request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowPower <= 1'b1;
    end else if (lowPower && reqValid) begin
      lowPower <= 1'b0;
    end else if (enterLp) begin
      lowPower <= 1'b1;
    end
  end

endmodule

// File: rtl/ddrcmd_latency.sv
module ddrcmd_latency
  import ddrcmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  output logic [LAT_W-1:0]  casLat,
  output logic [LAT_W-1:0]  casWrLat,
  output logic [LAT_W-1:0]  addLat,
  output logic [LAT_W-1:0]  rdLat,
  output logic [LAT_W-1:0]  wrLat
);

  logic [1:0] alSel;

  assign alSel    = mr1[4:3];
  assign casLat   = LAT_W'({mr0[2], mr0[6:4]}) + LAT_W'(4);
  assign casWrLat = LAT_W'(mr2[5:3]) + LAT_W'(5);

  always_comb begin
    if (alSel == 2'b00) addLat = '0;
    else                addLat = casLat - LAT_W'(alSel);
  end

  assign rdLat = casLat + addLat;
  assign wrLat = casWrLat + addLat;

endmodule

// File: rtl/ddrcmd_datapath.sv
module ddrcmd_datapath
  import ddrcmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [3:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqAutoPre,
  input  logic              reqBurstChop,
  output logic              memCke,
  output cmdPins_t          memCmd,
  output logic [BANK_W-1:0] memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] mr0,
  output logic [ADDR_W-1:0] mr1,
  output logic [ADDR_W-1:0] mr2
);

  localparam int AP_BIT  = 10;
  localparam int BC_BIT  = 12;
  localparam int LOW_COL = (COL_W < 10) ? COL_W : 10;

  logic [ADDR_W-1:0] colPins;
  logic [ADDR_W-1:0] rwAddr;
  logic [ADDR_W-1:0] flagAddr;
  logic              nextCke;
  cmdPins_t          nextCmd;
  logic [BANK_W-1:0] nextBa;
  logic [ADDR_W-1:0] nextAddr;

  // Column scatter: the pins at A[10] and A[12] are reserved for the flags
  generate
    for (genvar i = 0; i < ADDR_W; i++) begin : g_col
      if (i < LOW_COL) begin : g_low
        assign colPins[i] = reqAddr[i];
      end else if (i == 11 && COL_W > 10) begin : g_mid
        assign colPins[i] = reqAddr[10];
      end else if (i >= 13 && (i - 2) < COL_W) begin : g_high
        assign colPins[i] = reqAddr[i-2];
      end else begin : g_zero
        assign colPins[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    flagAddr = '0;
    flagAddr[AP_BIT] = reqAutoPre;
    rwAddr = colPins;
    rwAddr[AP_BIT] = reqAutoPre;
    rwAddr[BC_BIT] = reqBurstChop;
  end

  always_comb begin
    nextCke  = 1'b1;
    nextCmd  = PINS_NOP;
    nextBa   = '0;
    nextAddr = '0;
    if (strobe.issue) begin
      case (reqOp)
        OP_MODE_LOAD:    begin nextCmd = PINS_MODE_LOAD; nextBa = reqBank; nextAddr = reqAddr; end
        OP_REFRESH:      nextCmd = PINS_REFRESH;
        OP_PRECHARGE:    begin nextCmd = PINS_PRECHARGE; nextBa = reqBank; nextAddr = flagAddr; end
        OP_ACTIVATE:     begin nextCmd = PINS_ACTIVATE;  nextBa = reqBank; nextAddr = reqAddr; end
        OP_WRITE:        begin nextCmd = PINS_WRITE;     nextBa = reqBank; nextAddr = rwAddr; end
        OP_READ:         begin nextCmd = PINS_READ;      nextBa = reqBank; nextAddr = rwAddr; end
        OP_ZQ_CAL:       begin nextCmd = PINS_ZQ_CAL;    nextAddr = flagAddr; end
        OP_DESELECT:     nextCmd = PINS_DESELECT;
        OP_POWER_DOWN:   begin nextCke = 1'b0; nextCmd = PINS_DESELECT; end
        OP_SELF_REFRESH: begin nextCke = 1'b0; nextCmd = PINS_REFRESH; end
        default:         nextCmd = PINS_NOP;
      endcase
    end else if (strobe.wake) begin
      nextCmd = PINS_DESELECT;
    end else if (strobe.sleep) begin
      nextCke = 1'b0;
      nextCmd = PINS_DESELECT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCke  <= 1'b0;
      memCmd  <= PINS_DESELECT;
      memBa   <= '0;
      memAddr <= '0;
    end else begin
      memCke  <= nextCke;
      memCmd  <= nextCmd;
      memBa   <= nextBa;
      memAddr <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mr0 <= '0;
      mr1 <= '0;
      mr2 <= '0;
    end else if (strobe.issue && reqOp == OP_MODE_LOAD) begin
      if (reqBank == BANK_W'(0)) mr0 <= reqAddr;
      if (reqBank == BANK_W'(1)) mr1 <= reqAddr;
      if (reqBank == BANK_W'(2)) mr2 <= reqAddr;
    end
  end

endmodule

// File: rtl/ddrcmd_encoder.sv
module ddrcmd_encoder
  import ddrcmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqAutoPre,
  input  logic              reqBurstChop,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BANK_W-1:0] memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic [5:0]        casLat,
  output logic [5:0]        casWrLat,
  output logic [5:0]        addLat,
  output logic [5:0]        rdLat,
  output logic [5:0]        wrLat
);

  strobe_t           strobe;
  cmdPins_t          memCmd;
  logic [ADDR_W-1:0] mr0;
  logic [ADDR_W-1:0] mr1;
  logic [ADDR_W-1:0] mr2;

  ddrcmd_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  ddrcmd_datapath #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqOp        (reqOp),
    .reqBank      (reqBank),
    .reqAddr      (reqAddr),
    .reqAutoPre   (reqAutoPre),
    .reqBurstChop (reqBurstChop),
    .memCke       (memCke),
    .memCmd       (memCmd),
    .memBa        (memBa),
    .memAddr      (memAddr),
    .mr0          (mr0),
    .mr1          (mr1),
    .mr2          (mr2)
  );

  ddrcmd_latency #(.ADDR_W(ADDR_W)) lat_i (
    .mr0      (mr0),
    .mr1      (mr1),
    .mr2      (mr2),
    .casLat   (casLat),
    .casWrLat (casWrLat),
    .addLat   (addLat),
    .rdLat    (rdLat),
    .wrLat    (wrLat)
  );

  assign memCsN  = memCmd.csN;
  assign memRasN = memCmd.rasN;
  assign memCasN = memCmd.casN;
  assign memWeN  = memCmd.weN;

endmodule

// File: rtl/ddrcmd_encoder_chk.sv
module ddrcmd_encoder_chk
  import ddrcmd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [3:0]        reqOp,
  input logic [BANK_W-1:0] reqBank,
  input logic              reqAutoPre,
  input logic              memCke,
  input logic              memCsN,
  input logic              memRasN,
  input logic              memCasN,
  input logic              memWeN,
  input logic [BANK_W-1:0] memBa,
  input logic [ADDR_W-1:0] memAddr,
  input logic [5:0]        casLat,
  input logic [5:0]        addLat,
  input logic [5:0]        rdLat
);

  p_read_pins_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == OP_READ) |=>
      (memCke && !memCsN && memRasN && !memCasN && memWeN));

  p_pdown_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == OP_POWER_DOWN) |=>
      (!memCke && memCsN && !reqReady));

  p_sref_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == OP_SELF_REFRESH) |=>
      (!memCke && !memCsN && !memRasN && !memCasN && memWeN));

  p_wake_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (memCke && memCsN && reqReady));

  p_cke_low_not_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCke) |-> (!reqReady));

  p_precharge_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == OP_PRECHARGE) |=>
      (memAddr[10] == $past(reqAutoPre) && memBa == $past(reqBank)));

  p_idle_nop_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid) |=>
      (memCke && !memCsN && memRasN && memCasN && memWeN && memAddr == '0));

  p_read_sum_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdLat == casLat + addLat));

endmodule

bind ddrcmd_encoder ddrcmd_encoder_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqOp      (reqOp),
  .reqBank    (reqBank),
  .reqAutoPre (reqAutoPre),
  .memCke     (memCke),
  .memCsN     (memCsN),
  .memRasN    (memRasN),
  .memCasN    (memCasN),
  .memWeN     (memWeN),
  .memBa      (memBa),
  .memAddr    (memAddr),
  .casLat     (casLat),
  .addLat     (addLat),
  .rdLat      (rdLat)
);

// File: tb/ddrcmd_encoder_tb_top.sv
`timescale 1ns/1ps
module ddrcmd_encoder_tb_top;

  localparam int BANK_W = 3;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [3:0]        reqOp;
  logic [BANK_W-1:0] reqBank;
  logic [ADDR_W-1:0] reqAddr;
  logic              reqAutoPre;
  logic              reqBurstChop;
  logic              memCke, memCsN, memRasN, memCasN, memWeN;
  logic [BANK_W-1:0] memBa;
  logic [ADDR_W-1:0] memAddr;
  logic [5:0]        casLat, casWrLat, addLat, rdLat, wrLat;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  ddrcmd_encoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBank(reqBank), .reqAddr(reqAddr),
    .reqAutoPre(reqAutoPre), .reqBurstChop(reqBurstChop),
    .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memBa(memBa), .memAddr(memAddr),
    .casLat(casLat), .casWrLat(casWrLat), .addLat(addLat),
    .rdLat(rdLat), .wrLat(wrLat)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [2:0]  bank;
    logic [15:0] addr;
    logic        ap;
    logic        bc;
    logic [4:0]  pins;  // {cke, cs#, ras#, cas#, we#}
    logic [2:0]  ba;
    logic [15:0] a;
  } vec_t;

  // R13 activate/refresh, R7 scatter, R8 precharge/ZQ, R2 codes, R3 deselect, R9 load pins
  localparam vec_t VECS [15] = '{
    '{4'd13, 4'd3,  3'd5, 16'hABCD, 1'b0, 1'b0, 5'b10011, 3'd5, 16'hABCD},
    '{4'd7,  4'd4,  3'd2, 16'h03FF, 1'b0, 1'b0, 5'b10100, 3'd2, 16'h03FF},
    '{4'd7,  4'd4,  3'd1, 16'h0400, 1'b1, 1'b0, 5'b10100, 3'd1, 16'h0C00},
    '{4'd7,  4'd5,  3'd7, 16'h0800, 1'b0, 1'b1, 5'b10101, 3'd7, 16'h3000},
    '{4'd7,  4'd5,  3'd0, 16'h0FFF, 1'b1, 1'b1, 5'b10101, 3'd0, 16'h3FFF},
    '{4'd8,  4'd2,  3'd3, 16'hFFFF, 1'b1, 1'b0, 5'b10010, 3'd3, 16'h0400},
    '{4'd8,  4'd2,  3'd6, 16'hFFFF, 1'b0, 1'b1, 5'b10010, 3'd6, 16'h0000},
    '{4'd8,  4'd6,  3'd5, 16'hFFFF, 1'b1, 1'b0, 5'b10110, 3'd0, 16'h0400},
    '{4'd8,  4'd6,  3'd5, 16'hFFFF, 1'b0, 1'b0, 5'b10110, 3'd0, 16'h0000},
    '{4'd13, 4'd1,  3'd4, 16'hFFFF, 1'b1, 1'b1, 5'b10001, 3'd0, 16'h0000},
    '{4'd2,  4'd7,  3'd4, 16'hFFFF, 1'b1, 1'b1, 5'b10111, 3'd0, 16'h0000},
    '{4'd3,  4'd8,  3'd4, 16'hFFFF, 1'b1, 1'b1, 5'b11111, 3'd0, 16'h0000},
    '{4'd2,  4'd15, 3'd4, 16'hFFFF, 1'b1, 1'b1, 5'b10111, 3'd0, 16'h0000},
    '{4'd9,  4'd0,  3'd0, 16'h0070, 1'b0, 1'b0, 5'b10000, 3'd0, 16'h0070},
    '{4'd9,  4'd0,  3'd2, 16'h0018, 1'b0, 1'b0, 5'b10000, 3'd2, 16'h0018}
  };

  function automatic logic [4:0] pins();
    return {memCke, memCsN, memRasN, memCasN, memWeN};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkLat(input string tag, input int cl, input int cwl, input int al);
    check({tag, " CL"},  32'(casLat),   32'(cl));
    check({tag, " CWL"}, 32'(casWrLat), 32'(cwl));
    check({tag, " AL"},  32'(addLat),   32'(al));
    check({tag, " RL"},  32'(rdLat),    32'(cl + al));
    check({tag, " WL"},  32'(wrLat),    32'(cwl + al));
  endtask

  // Drive at a falling edge, let one rising edge take it, return at the next falling edge
  task automatic issue(input logic [3:0] op, input logic [2:0] bank, input logic [15:0] addr,
                       input logic ap, input logic bc);
    reqValid = 1'b1; reqOp = op; reqBank = bank; reqAddr = addr;
    reqAutoPre = ap; reqBurstChop = bc;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = 4'd7; reqBank = '0; reqAddr = '0;
    reqAutoPre = 1'b0; reqBurstChop = 1'b0;
    idle(3);
    check("R1 pins in reset", 32'(pins()), 32'b01111);
    rstN = 1'b1;
    idle(2);
    check("R1 pins after reset", 32'(pins()), 32'b01111);
    check("R1 ready", 32'(reqReady), 32'd0);
    check("R1 addr", 32'(memAddr), 32'd0);
    checkLat("R1", 4, 5, 0);

    // R6 first request wakes the encoder
    reqValid = 1'b1; reqOp = 4'd7;
    @(posedge clk); @(negedge clk);
    check("R6 wake pins", 32'(pins()), 32'b11111);
    check("R6 wake ready", 32'(reqReady), 32'd1);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check("R6 deferred accept", 32'(pins()), 32'b10111);

    // R12 idle NOP
    idle(2);
    check("R12 idle pins", 32'(pins()), 32'b10111);
    check("R12 idle addr", 32'(memAddr), 32'd0);

    foreach (VECS[i]) begin
      issue(VECS[i].op, VECS[i].bank, VECS[i].addr, VECS[i].ap, VECS[i].bc);
      check($sformatf("R%0d vec%0d pins", VECS[i].req, i), 32'(pins()), 32'(VECS[i].pins));
      check($sformatf("R%0d vec%0d ba", VECS[i].req, i), 32'(memBa), 32'(VECS[i].ba));
      check($sformatf("R%0d vec%0d addr", VECS[i].req, i), 32'(memAddr), 32'(VECS[i].a));
    end

    // R10 after MR0=0x0070 and MR2=0x0018
    checkLat("R10 cl11 cwl8", 11, 8, 0);
    issue(4'd0, 3'd0, 16'h0024, 1'b0, 1'b0);
    checkLat("R10 cl14", 14, 8, 0);
    // R11 every additive latency selection
    issue(4'd0, 3'd1, 16'h0008, 1'b0, 1'b0);
    checkLat("R11 al sel1", 14, 8, 13);
    issue(4'd0, 3'd1, 16'h0010, 1'b0, 1'b0);
    checkLat("R11 al sel2", 14, 8, 12);
    issue(4'd0, 3'd1, 16'h0018, 1'b0, 1'b0);
    checkLat("R11 al sel3", 14, 8, 11);
    // R9 mode load to bank 3 leaves shadows alone
    issue(4'd0, 3'd3, 16'hFFFF, 1'b0, 1'b0);
    check("R9 load bank3 pins", 32'(pins()), 32'b10000);
    check("R9 load bank3 addr", 32'(memAddr), 32'hFFFF);
    checkLat("R9 bank3 ignored", 14, 8, 11);
    issue(4'd0, 3'd1, 16'h0000, 1'b0, 1'b0);
    checkLat("R11 al sel0", 14, 8, 0);

    // R4 power-down entry and hold
    issue(4'd9, 3'd0, 16'h0000, 1'b0, 1'b0);
    check("R4 entry pins", 32'(pins()), 32'b01111);
    check("R4 entry ready", 32'(reqReady), 32'd0);
    idle(3);
    check("R4 hold pins", 32'(pins()), 32'b01111);
    check("R4 hold ready", 32'(reqReady), 32'd0);
    reqValid = 1'b1; reqOp = 4'd5; reqBank = 3'd4; reqAddr = 16'h0005;
    reqAutoPre = 1'b0; reqBurstChop = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 exit pins", 32'(pins()), 32'b11111);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check("R6 read after exit", 32'(pins()), 32'b10101);
    check("R6 read addr", 32'(memAddr), 32'h0005);

    // R5 self-refresh entry then deselect with CKE low
    issue(4'd10, 3'd0, 16'h0000, 1'b0, 1'b0);
    check("R5 entry pins", 32'(pins()), 32'b00001);
    check("R5 entry ready", 32'(reqReady), 32'd0);
    idle(1);
    check("R5 follow pins", 32'(pins()), 32'b01111);
    idle(2);
    check("R5 hold pins", 32'(pins()), 32'b01111);
    reqValid = 1'b1; reqOp = 4'd7;
    @(posedge clk); @(negedge clk);
    check("R6 sref exit pins", 32'(pins()), 32'b11111);
    check("R6 sref exit ready", 32'(reqReady), 32'd1);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check("R6 sref nop", 32'(pins()), 32'b10111);

    // R1 reset clears shadows again
    rstN = 1'b0;
    idle(1);
    rstN = 1'b1;
    check("R1 re-reset pins", 32'(pins()), 32'b01111);
    checkLat("R1 re-reset", 4, 5, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule